// File: doc/BRIEF.md
# Per-Processor Interrupt Presenter

This block sits between a source controller and one processor. It keeps the state that decides whether the processor should be interrupted:
- the processor's current priority;
- a software-set inter-processor request priority;
- the priority and 24-bit identity of the one interrupt on offer;
- a flag that records that a delivery was turned away.

A lower number means a more favoured priority, and 0xFF means none or masked.

The source controller offers deliveries and learns, one cycle later, whether each was taken. The processor issues commands: accept, set priority, set request priority, end-of-interrupt and poll. Each command or delivery is applied as one atomic update of the state. The block raises `irqOut` while a favoured interrupt waits. It returns work to the source side on three outbound channels, each held until its ready is seen:
- displaced sources, to be delivered again;
- resend requests, sent when the priority drops after a refusal;
- end-of-interrupt notifications.

Top module: `irq_presenter`

## Requirements
- R1: After reset, the processor priority is 0x00, the request priority is 0xFF, the pending priority is 0xFF, the pending ID is 0 and `irqOut` is low.
- R2: A delivery is taken (`dlvAcc`=1 with `dlvDone`, one cycle after the handshake) only when the processor priority, the request priority and the pending priority are all numerically greater than its priority. When it is taken, the pending ID and priority are loaded and any previous pending ID is sent on the reject channel. When it is refused, the need-resend flag is set.
- R3: `irqOut` is high exactly when the pending ID is non-zero and the pending priority is below the processor priority.
- R4: Command op 0 (accept) returns the word {priority[31:24], pending ID[23:0]} as it stood before the command. If the pending ID was non-zero, the processor priority becomes the pending priority and the pending state is cleared to ID 0 and priority 0xFF.
- R5: Command op 2 (set request priority, value in data[7:0]) loads the request priority. If the value is below the processor priority and not above the pending priority, the IPI ID (default 2) is presented at that priority and the old pending ID is rejected. If the value rose and exceeds the processor priority, a set need-resend flag becomes a resend request and is cleared.
- R6: Command op 1 (set priority, data[7:0]) with a more favoured value loads it. If the value is not above the pending priority, it rejects the pending ID and clears the pending state. An equal value changes nothing.
- R7: A less favoured priority (op 1) loads the new value. If the request priority is below the new value and not above the pending priority, the IPI ID is presented at the request priority. A set need-resend flag always becomes a resend request and is cleared.
- R8: Command op 3 (end of interrupt) applies data[31:24] as a priority lowering in the manner of R7. It then sends data[23:0] on the notification channel, unless that value is 0 or the IPI ID.
- R9: Command op 4 (poll) returns the accept word and the request priority in `rspMfrr` and changes no state.
- R10: A displaced IPI ID is never sent on the reject channel.
- R11: When a command and a delivery are offered in the same cycle, the command is applied first and `dlvReady` stays low until the command has been taken.
- R12: While any outbound channel holds a request, `cmdReady` and `dlvReady` are low. Each outbound request and its ID stay stable until its ready is seen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Processor command offered |
| cmdReady | output | 1 | Command can be taken |
| cmdOp | input | 3 | 0 accept, 1 set priority, 2 set request priority, 3 end of interrupt, 4 poll |
| cmdData | input | 32 | Command operand |
| rspValid | output | 1 | Pulse with the accept or poll result |
| rspWord | output | 32 | {processor priority, pending ID} |
| rspMfrr | output | 8 | Request priority (poll) |
| dlvValid | input | 1 | Delivery offered by the source side |
| dlvReady | output | 1 | Delivery can be taken |
| dlvSrc | input | 24 | Delivered source ID (non-zero) |
| dlvPrio | input | 8 | Delivered priority |
| dlvDone | output | 1 | Pulse one cycle after a delivery is taken |
| dlvAcc | output | 1 | Delivery accepted (valid with dlvDone) |
| irqOut | output | 1 | Interrupt request to the processor |
| rejValid | output | 1 | Displaced source waiting |
| rejReady | input | 1 | Source side takes the displaced source |
| rejSrc | output | 24 | Displaced source ID |
| rsndValid | output | 1 | Resend request waiting |
| rsndReady | input | 1 | Source side takes the resend request |
| ntfValid | output | 1 | End-of-interrupt notification waiting |
| ntfReady | input | 1 | Source side takes the notification |
| ntfSrc | output | 24 | Source ID being ended |

## Verification
The bench targets the strict comparison at equal priorities:
- A delivery at exactly the processor priority must be refused. A design that uses a non-strict test would take it and interrupt the processor too early.
- A priority raise to exactly the pending priority must reject the pending source. A design that gets this wrong keeps a source the processor has just masked.

The bench also targets the points where requests are lost or leak out. A lazy resend must appear only after a refusal, and only on a priority drop or a rising request priority. A design that drops it leaves a source stranded. A displaced IPI must never reach the reject channel, or the source side would chase an ID it does not own.

It also checks same-cycle ordering. Here the command must win; a delivery taken first would be accepted at the old priority instead of being refused.

// File: rtl/ipres_pkg.sv
package ipres_pkg;
  localparam int PRIO_W = 8;
  localparam int SRC_W  = 24;
  localparam int WORD_W = PRIO_W + SRC_W;

  typedef enum logic [2:0] {
    OP_ACCEPT   = 3'd0,
    OP_SET_CPPR = 3'd1,
    OP_SET_MFRR = 3'd2,
    OP_EOI      = 3'd3,
    OP_POLL     = 3'd4
  } ipres_op_e;

  // One strobe per atomic state update, issued by the control to the datapath
  typedef struct packed {
    logic              accept;
    logic              poll;
    logic              raise;
    logic              lower;
    logic              mfrrSet;
    logic              deliver;
    logic [PRIO_W-1:0] prio;
    logic [SRC_W-1:0]  src;
  } ipres_strobe_t;
endpackage

// File: rtl/ipres_dpath.sv
module ipres_dpath
  import ipres_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_ID = 24'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ipres_strobe_t     stb,
  output logic [PRIO_W-1:0] cpprQ,
  output logic [PRIO_W-1:0] mfrrQ,
  output logic [SRC_W-1:0]  xisrQ,
  output logic              irqOut,
  output logic              dlvOk,
  output logic              rejFire,
  output logic [SRC_W-1:0]  rejId,
  output logic              rsndFire
);
  localparam logic [PRIO_W-1:0] NONE = '1;

  logic [PRIO_W-1:0] pendQ, cpprD, mfrrD, pendD;
  logic [SRC_W-1:0]  xisrD;
  logic              needRsndQ, needRsndD;
  logic              xisrIsSrc;

  assign xisrIsSrc = (xisrQ != '0) && (xisrQ != IPI_ID);
  assign rejId     = xisrQ;

  always_comb begin
    cpprD     = cpprQ;
    mfrrD     = mfrrQ;
    pendD     = pendQ;
    xisrD     = xisrQ;
    needRsndD = needRsndQ;
    rejFire   = 1'b0;
    rsndFire  = 1'b0;
    dlvOk     = 1'b0;
    if (stb.deliver) begin
      dlvOk = (cpprQ > stb.prio) && (mfrrQ > stb.prio) && (pendQ > stb.prio);
      if (dlvOk) begin
        rejFire = xisrIsSrc;
        xisrD   = stb.src;
        pendD   = stb.prio;
      end else begin
        needRsndD = 1'b1;
      end
    end else if (stb.accept) begin
      if (xisrQ != '0) begin
        cpprD = pendQ;
        pendD = NONE;
        xisrD = '0;
      end
    end else if (stb.raise) begin
      cpprD = stb.prio;
      if (stb.prio <= pendQ) begin
        rejFire = xisrIsSrc;
        xisrD   = '0;
        pendD   = NONE;
      end
    end else if (stb.lower) begin
      cpprD = stb.prio;
      if ((mfrrQ < stb.prio) && (mfrrQ <= pendQ)) begin
        rejFire = xisrIsSrc;
        pendD   = mfrrQ;
        xisrD   = IPI_ID;
      end
      rsndFire  = needRsndQ;
      needRsndD = 1'b0;
    end else if (stb.mfrrSet) begin
      mfrrD = stb.prio;
      if ((stb.prio < cpprQ) && (stb.prio <= pendQ)) begin
        rejFire = xisrIsSrc;
        pendD   = stb.prio;
        xisrD   = IPI_ID;
      end
      if ((stb.prio > mfrrQ) && (stb.prio > cpprQ)) begin
        rsndFire  = needRsndQ;
        needRsndD = 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpprQ     <= '0;
      mfrrQ     <= NONE;
      pendQ     <= NONE;
      xisrQ     <= '0;
      needRsndQ <= 1'b0;
    end else begin
      cpprQ     <= cpprD;
      mfrrQ     <= mfrrD;
      pendQ     <= pendD;
      xisrQ     <= xisrD;
      needRsndQ <= needRsndD;
    end
  end

  assign irqOut = (xisrQ != '0) && (pendQ < cpprQ);

  // R4
  accept_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.accept && xisrQ != '0) |=> (xisrQ == '0 && pendQ == NONE && cpprQ == $past(pendQ)));
  // R9
  poll_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stb.poll |=> ($stable(cpprQ) && $stable(xisrQ) && $stable(mfrrQ) && $stable(pendQ) && $stable(needRsndQ)));
  // R2
  deliver_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (stb.deliver && dlvOk) |=> (xisrQ == $past(stb.src) && pendQ == $past(stb.prio)));
endmodule

// File: rtl/ipres_ctrl.sv
module ipres_ctrl
  import ipres_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_ID = 24'd2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmdValid,
  output logic              cmdReady,
  input  logic [2:0]        cmdOp,
  input  logic [WORD_W-1:0] cmdData,
  output logic              rspValid,
  output logic [WORD_W-1:0] rspWord,
  output logic [PRIO_W-1:0] rspMfrr,
  input  logic              dlvValid,
  output logic              dlvReady,
  input  logic [SRC_W-1:0]  dlvSrc,
  input  logic [PRIO_W-1:0] dlvPrio,
  output logic              dlvDone,
  output logic              dlvAcc,
  output logic              rejValid,
  input  logic              rejReady,
  output logic [SRC_W-1:0]  rejSrc,
  output logic              rsndValid,
  input  logic              rsndReady,
  output logic              ntfValid,
  input  logic              ntfReady,
  output logic [SRC_W-1:0]  ntfSrc,
  output ipres_strobe_t     stb,
  input  logic [PRIO_W-1:0] cpprQ,
  input  logic [PRIO_W-1:0] mfrrQ,
  input  logic [SRC_W-1:0]  xisrQ,
  input  logic              dlvOk,
  input  logic              rejFire,
  input  logic [SRC_W-1:0]  rejId,
  input  logic              rsndFire
);
  logic busy, cmdFire, dlvFire, ntfFire;
  logic [PRIO_W-1:0] lowByte, topByte;
  logic [SRC_W-1:0]  eoiSrc;

  assign busy     = rejValid || rsndValid || ntfValid;
  assign cmdReady = !busy;
  assign dlvReady = !busy && !cmdValid;
  assign cmdFire  = cmdValid && cmdReady;
  assign dlvFire  = dlvValid && dlvReady;
  assign lowByte  = cmdData[PRIO_W-1:0];
  assign topByte  = cmdData[WORD_W-1:SRC_W];
  assign eoiSrc   = cmdData[SRC_W-1:0];
  assign ntfFire  = cmdFire && (cmdOp == OP_EOI) && (eoiSrc != '0) && (eoiSrc != IPI_ID);

  always_comb begin
    stb = '0;
    if (cmdFire) begin
      stb.prio = lowByte;
      case (cmdOp)
        OP_ACCEPT:   stb.accept = 1'b1;
        OP_POLL:     stb.poll = 1'b1;
        OP_SET_MFRR: stb.mfrrSet = 1'b1;
        OP_SET_CPPR: begin
          stb.raise = (lowByte < cpprQ);
          stb.lower = (lowByte > cpprQ);
        end
        OP_EOI: begin
          stb.lower = 1'b1;
          stb.prio  = topByte;
        end
        default: ;
      endcase
    end else if (dlvFire) begin
      stb.deliver = 1'b1;
      stb.prio    = dlvPrio;
      stb.src     = dlvSrc;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rspValid  <= 1'b0;
      rspWord   <= '0;
      rspMfrr   <= '0;
      dlvDone   <= 1'b0;
      dlvAcc    <= 1'b0;
      rejValid  <= 1'b0;
      rejSrc    <= '0;
      rsndValid <= 1'b0;
      ntfValid  <= 1'b0;
      ntfSrc    <= '0;
    end else begin
      rspValid <= cmdFire && ((cmdOp == OP_ACCEPT) || (cmdOp == OP_POLL));
      if (cmdFire) begin
        rspWord <= {cpprQ, xisrQ};
        rspMfrr <= mfrrQ;
      end
      dlvDone <= dlvFire && !cmdFire;
      dlvAcc  <= dlvOk;
      if (rejFire) begin
        rejValid <= 1'b1;
        rejSrc   <= rejId;
      end else if (rejReady) begin
        rejValid <= 1'b0;
      end
      if (rsndFire) rsndValid <= 1'b1;
      else if (rsndReady) rsndValid <= 1'b0;
      if (ntfFire) begin
        ntfValid <= 1'b1;
        ntfSrc   <= eoiSrc;
      end else if (ntfReady) begin
        ntfValid <= 1'b0;
      end
    end
  end

  // R12
  rej_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rejValid && !rejReady) |=> (rejValid && $stable(rejSrc)));
  // R12
  ntf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ntfValid && !ntfReady) |=> (ntfValid && $stable(ntfSrc)));
  // R10
  no_ipi_reject_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rejValid |-> (rejSrc != IPI_ID));
  // R11
  one_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({stb.accept, stb.poll, stb.raise, stb.lower, stb.mfrrSet, stb.deliver}));
endmodule

// File: rtl/irq_presenter.sv
module irq_presenter
  import ipres_pkg::*;
#(
  parameter logic [SRC_W-1:0] IPI_ID = 24'd2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmdValid,
  output logic        cmdReady,
  input  logic [2:0]  cmdOp,
  input  logic [31:0] cmdData,
  output logic        rspValid,
  output logic [31:0] rspWord,
  output logic [7:0]  rspMfrr,
  input  logic        dlvValid,
  output logic        dlvReady,
  input  logic [23:0] dlvSrc,
  input  logic [7:0]  dlvPrio,
  output logic        dlvDone,
  output logic        dlvAcc,
  output logic        irqOut,
  output logic        rejValid,
  input  logic        rejReady,
  output logic [23:0] rejSrc,
  output logic        rsndValid,
  input  logic        rsndReady,
  output logic        ntfValid,
  input  logic        ntfReady,
  output logic [23:0] ntfSrc
);
  ipres_strobe_t     stb;
  logic [PRIO_W-1:0] cpprQ, mfrrQ;
  logic [SRC_W-1:0]  xisrQ, rejId;
  logic              dlvOk, rejFire, rsndFire;

  ipres_ctrl #(.IPI_ID(IPI_ID)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cmdValid(cmdValid), .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdData(cmdData),
    .rspValid(rspValid), .rspWord(rspWord), .rspMfrr(rspMfrr),
    .dlvValid(dlvValid), .dlvReady(dlvReady), .dlvSrc(dlvSrc), .dlvPrio(dlvPrio),
    .dlvDone(dlvDone), .dlvAcc(dlvAcc),
    .rejValid(rejValid), .rejReady(rejReady), .rejSrc(rejSrc),
    .rsndValid(rsndValid), .rsndReady(rsndReady),
    .ntfValid(ntfValid), .ntfReady(ntfReady), .ntfSrc(ntfSrc),
    .stb(stb), .cpprQ(cpprQ), .mfrrQ(mfrrQ), .xisrQ(xisrQ),
    .dlvOk(dlvOk), .rejFire(rejFire), .rejId(rejId), .rsndFire(rsndFire)
  );

  ipres_dpath #(.IPI_ID(IPI_ID)) u_dpath (
    .clk(clk), .rst_n(rst_n), .stb(stb),
    .cpprQ(cpprQ), .mfrrQ(mfrrQ), .xisrQ(xisrQ), .irqOut(irqOut),
    .dlvOk(dlvOk), .rejFire(rejFire), .rejId(rejId), .rsndFire(rsndFire)
  );
endmodule

// File: tb/irq_presenter_bench.sv
`timescale 1ns/1ps
module irq_presenter_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmdValid = 1'b0, dlvValid = 1'b0;
  logic [2:0]  cmdOp = '0;
  logic [31:0] cmdData = '0;
  logic [23:0] dlvSrc = '0;
  logic [7:0]  dlvPrio = '0;
  logic        rejReady = 1'b0, rsndReady = 1'b0, ntfReady = 1'b0;
  logic        cmdReady, rspValid, dlvReady, dlvDone, dlvAcc, irqOut;
  logic        rejValid, rsndValid, ntfValid;
  logic [31:0] rspWord;
  logic [7:0]  rspMfrr;
  logic [23:0] rejSrc, ntfSrc;
  int nChk = 0, nBad = 0;
  bit finished = 1'b0;

  localparam logic [2:0] ACC = 3'd0, SCP = 3'd1, SMF = 3'd2, EOI = 3'd3, POL = 3'd4;

  always #2 clk = ~clk;

  irq_presenter u_irq_presenter (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic doCmd(input logic [2:0] op, input logic [31:0] data);
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdData = data;
    @(negedge clk);
    cmdValid = 1'b0;
  endtask

  task automatic doDlv(input logic [23:0] src, input logic [7:0] prio, input logic expAcc, input string req);
    @(negedge clk);
    dlvValid = 1'b1; dlvSrc = src; dlvPrio = prio;
    @(negedge clk);
    dlvValid = 1'b0;
    check({req, " dlvDone"}, {31'd0, dlvDone}, 32'd1);
    check({req, " dlvAcc"}, {31'd0, dlvAcc}, {31'd0, expAcc});
  endtask

  task automatic poll(input logic [31:0] expWord, input logic [7:0] expMfrr, input string req);
    doCmd(POL, 32'd0);
    check({req, " poll valid"}, {31'd0, rspValid}, 32'd1);
    check({req, " poll word"}, rspWord, expWord);
    check({req, " poll mfrr"}, {24'd0, rspMfrr}, {24'd0, expMfrr});
  endtask

  task automatic drain();
    @(negedge clk);
    rejReady = 1'b1; rsndReady = 1'b1; ntfReady = 1'b1;
    @(negedge clk);
    rejReady = 1'b0; rsndReady = 1'b0; ntfReady = 1'b0;
  endtask

  task automatic tReset();
    check("R1 irqOut", {31'd0, irqOut}, 32'd0);
    poll(32'h0000_0000, 8'hFF, "R1");
  endtask

  task automatic tRefuseResend();
    doDlv(24'h000123, 8'h05, 1'b0, "R2 refuse at cppr 0");
    doCmd(SCP, 32'h0000_00FF);
    check("R7 resend after lowering", {31'd0, rsndValid}, 32'd1);
    drain();
    check("R7 resend taken", {31'd0, rsndValid}, 32'd0);
    poll(32'hFF00_0000, 8'hFF, "R7");
  endtask

  task automatic tAccept();
    doDlv(24'h000123, 8'h20, 1'b1, "R2 accept");
    check("R3 irq raised", {31'd0, irqOut}, 32'd1);
    doCmd(ACC, 32'd0);
    check("R4 accept valid", {31'd0, rspValid}, 32'd1);
    check("R4 accept word", rspWord, 32'hFF00_0123);
    check("R3 irq after accept", {31'd0, irqOut}, 32'd0);
    poll(32'h2000_0000, 8'hFF, "R4");
  endtask

  task automatic tEoi();
    doDlv(24'h000456, 8'h20, 1'b0, "R2 equal prio refused");
    doCmd(EOI, 32'hFF00_0123);
    check("R8 resend", {31'd0, rsndValid}, 32'd1);
    check("R8 notify", {31'd0, ntfValid}, 32'd1);
    check("R8 notify src", {8'd0, ntfSrc}, 32'h0000_0123);
    check("R12 cmdReady low", {31'd0, cmdReady}, 32'd0);
    drain();
    poll(32'hFF00_0000, 8'hFF, "R8");
  endtask

  task automatic tDisplace();
    doDlv(24'h000111, 8'h40, 1'b1, "R2 first");
    doDlv(24'h000222, 8'h30, 1'b1, "R2 displacing");
    check("R2 reject valid", {31'd0, rejValid}, 32'd1);
    check("R2 reject src", {8'd0, rejSrc}, 32'h0000_0111);
    check("R12 cmdReady", {31'd0, cmdReady}, 32'd0);
    check("R12 dlvReady", {31'd0, dlvReady}, 32'd0);
    @(negedge clk);
    check("R12 reject held", {31'd0, rejValid}, 32'd1);
    drain();
    doCmd(SCP, 32'h0000_0030);
    check("R6 reject on raise", {31'd0, rejValid}, 32'd1);
    check("R6 reject src", {8'd0, rejSrc}, 32'h0000_0222);
    check("R3 irq cleared", {31'd0, irqOut}, 32'd0);
    drain();
    doCmd(SCP, 32'h0000_0030);
    check("R6 equal no reject", {31'd0, rejValid}, 32'd0);
    poll(32'h3000_0000, 8'hFF, "R6");
  endtask

  task automatic tIpi();
    doCmd(SMF, 32'h0000_0010);
    check("R5 no reject of empty", {31'd0, rejValid}, 32'd0);
    check("R5 irq", {31'd0, irqOut}, 32'd1);
    poll(32'h3000_0002, 8'h10, "R5");
    doDlv(24'h000333, 8'h08, 1'b1, "R10 displace IPI");
    check("R10 IPI not rejected", {31'd0, rejValid}, 32'd0);
    poll(32'h3000_0333, 8'h10, "R10");
    doCmd(SMF, 32'h0000_0005);
    check("R5 reject", {31'd0, rejValid}, 32'd1);
    check("R5 reject src", {8'd0, rejSrc}, 32'h0000_0333);
    drain();
    doCmd(ACC, 32'd0);
    check("R4 accept IPI", rspWord, 32'h3000_0002);
    doDlv(24'h000444, 8'h06, 1'b0, "R2 refuse");
    doCmd(SMF, 32'h0000_00FF);
    check("R5 resend on rise", {31'd0, rsndValid}, 32'd1);
    drain();
    doCmd(EOI, 32'hFF00_0002);
    check("R8 no resend", {31'd0, rsndValid}, 32'd0);
    check("R8 IPI no notify", {31'd0, ntfValid}, 32'd0);
    check("R3 idle", {31'd0, irqOut}, 32'd0);
    poll(32'hFF00_0000, 8'hFF, "R8");
  endtask

  task automatic tLowerIpi();
    doCmd(SMF, 32'h0000_0050);
    doCmd(ACC, 32'd0);
    check("R4 accept", rspWord, 32'hFF00_0002);
    check("R3 low after accept", {31'd0, irqOut}, 32'd0);
    doCmd(SCP, 32'h0000_0080);
    check("R7 IPI re-presented", {31'd0, irqOut}, 32'd1);
    poll(32'h8000_0002, 8'h50, "R7");
    poll(32'h8000_0002, 8'h50, "R9 repeat");
    check("R9 irq unchanged", {31'd0, irqOut}, 32'd1);
  endtask

  task automatic tOrder();
    @(negedge clk);
    cmdValid = 1'b1; cmdOp = SCP; cmdData = 32'h0000_0010;
    dlvValid = 1'b1; dlvSrc = 24'h000555; dlvPrio = 8'h40;
    #1;
    check("R11 dlvReady low", {31'd0, dlvReady}, 32'd0);
    @(negedge clk);
    cmdValid = 1'b0;
    @(negedge clk);
    dlvValid = 1'b0;
    check("R11 dlvDone", {31'd0, dlvDone}, 32'd1);
    check("R11 refused after command", {31'd0, dlvAcc}, 32'd0);
    check("R10 no reject", {31'd0, rejValid}, 32'd0);
    poll(32'h1000_0000, 8'h50, "R11");
  endtask

  initial begin
    repeat (4) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tRefuseResend();
    tAccept();
    tEoi();
    tDisplace();
    tIpi();
    tLowerIpi();
    tOrder();
    if (!finished) begin
      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      nChk++;
      nBad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", nChk, nBad);
      $finish;
    end
  end
endmodule